// File: doc/BRIEF.md
# Memory Checksum Engine

This block is a small register-mapped engine that computes a 32-bit polynomial checksum over a stream of data words. A bus master, usually a DMA channel that walks a memory range, reads each item from memory and writes it to the input register. Each such write folds the written bits into a running checksum in a single clock cycle. After the last item, software reads the result register and compares it with the value it expects.

The result register is seeded by a plain write before a sequence starts. All ones is the usual seed, but any value may be used. The checksum uses the generator polynomial 0x04C11DB7. Data is fed most-significant bit first, with no bit reflection on input or output and no final inversion, so the register always holds the raw remainder. The engine accepts one access per cycle and never inserts wait states.

Top module: `mem_crc_checker`

## Requirements
- R1: After a synchronous reset the result register reads 0xFFFFFFFF.
- R2: A write to offset 0x4 loads all 32 bits of `wdata` into the result register on the next clock edge, whatever the size code.
- R3: A write to offset 0x0 with size code 2 folds `wdata[31:0]` into the checksum. Bits go in from bit 31 down to bit 0. For each bit the feedback is result bit 31 XOR the data bit, the register shifts left by one, and it is XORed with 0x04C11DB7 when the feedback is 1. There is no reflection and no final XOR.
- R4: A write to offset 0x0 with size code 0 folds only `wdata[7:0]`, MSB first, and bits 31:8 have no effect. With seed 0xFFFFFFFF, the bytes 0x31 to 0x39 in order give 0x0376E6E7.
- R5: A write to offset 0x0 with size code 1 folds only `wdata[15:0]`, MSB first.
- R6: A write to offset 0x0 with size code 3 leaves the result register unchanged.
- R7: Writes to any offset other than 0x0 and 0x4 leave the result register unchanged.
- R8: `rdata` is registered. One cycle after `addr` is 0x4 it shows the result register as it stood before that clock edge. For any other address it shows zero, so the input register reads as zero.
- R9: `ready` is high from the second cycle after reset is released. Back-to-back writes on consecutive cycles are each folded in order, with no wait states.
- R10: In a cycle with no write, the result register holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Write strobe |
| size | input | 2 | Write size code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = reserved |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| ready | output | 1 | Access accepted (no wait states) |

## Verification
A wrong fold shows up at the port as a wrong result word on the very next read. The state is never reset or corrected by later data, so any error in the polynomial, the bit order or the lane width stays in every result until the next seed. The bench therefore reads the result after short bursts and after long bursts, and compares each value with a bit-serial model. A write that is dropped or applied twice also breaks every later read, while a stray update from an ignored write shows up in the read that follows it.

// File: rtl/mcc_pkg.sv
package mcc_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;
  localparam int          LANES    = 3;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } size_e;
endpackage

// File: rtl/mcc_crc_lane.sv
// Folds W data bits, MSB first, into a 32-bit remainder in one cycle.
module mcc_crc_lane
  import mcc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [CRC_W-1:0] crc_in,
  input  logic [W-1:0]     data,
  output logic [CRC_W-1:0] crc_out
);
  logic [CRC_W-1:0] c;
  logic             fb;

  always_comb begin
    c  = crc_in;
    fb = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ data[i];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    crc_out = c;
  end
endmodule

// File: rtl/mcc_decode.sv
// Address and size decode for the checksum engine.
module mcc_decode
  import mcc_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int IN_OFS  = 0,
  parameter int RES_OFS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        size,
  output logic              data_we,
  output logic              seed_we,
  output logic              sel_res,
  output logic [1:0]        lane_idx
);
  logic hit_in;
  logic hit_res;

  always_comb begin
    hit_in   = (addr == ADDR_W'(IN_OFS));
    hit_res  = (addr == ADDR_W'(RES_OFS));
    sel_res  = hit_res;
    seed_we  = wr_en && hit_res;
    data_we  = wr_en && hit_in && (size_e'(size) != SZ_RSVD);
    lane_idx = size;
  end
endmodule

// File: rtl/mem_crc_checker.sv
// Register-mapped checksum engine: input register at IN_OFS, result at RES_OFS.
module mem_crc_checker
  import mcc_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          IN_OFS   = 0,
  parameter int          RES_OFS  = 4,
  parameter logic [31:0] RST_SEED = 32'hFFFFFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [1:0]        size,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              ready
);
  logic             data_we;
  logic             seed_we;
  logic             sel_res;
  logic [1:0]       lane_idx;
  logic [CRC_W-1:0] result_q;
  logic [CRC_W-1:0] fold;
  logic [CRC_W-1:0] lane_out [LANES];

  mcc_decode #(
    .ADDR_W (ADDR_W),
    .IN_OFS (IN_OFS),
    .RES_OFS(RES_OFS)
  ) u_decode (
    .addr    (addr),
    .wr_en   (wr_en),
    .size    (size),
    .data_we (data_we),
    .seed_we (seed_we),
    .sel_res (sel_res),
    .lane_idx(lane_idx)
  );

  // One folding lane per supported write width: 8, 16, 32 bits.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int LW = 8 << g;
    mcc_crc_lane #(.W(LW)) u_lane (
      .crc_in (result_q),
      .data   (wdata[LW-1:0]),
      .crc_out(lane_out[g])
    );
  end

  always_comb begin
    case (size_e'(lane_idx))
      SZ_BYTE: fold = lane_out[0];
      SZ_HALF: fold = lane_out[1];
      SZ_WORD: fold = lane_out[2];
      default: fold = result_q;
    endcase
  end

  // Seed write wins over any data update.
  always_ff @(posedge clk) begin
    if (rst)          result_q <= RST_SEED;
    else if (seed_we) result_q <= wdata;
    else if (data_we) result_q <= fold;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      rdata <= sel_res ? result_q : '0;
      ready <= 1'b1;
    end
  end
endmodule

// File: rtl/mcc_checker.sv
// Protocol checks on the checksum engine, bound to the top module.
module mcc_checker #(
  parameter int          ADDR_W   = 4,
  parameter int          IN_OFS   = 0,
  parameter int          RES_OFS  = 4,
  parameter logic [31:0] RST_SEED = 32'hFFFFFFFF
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [1:0]        size,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              ready,
  input logic [31:0]       result
);
  // R1
  assert_reset_value_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> result == RST_SEED);

  // R2
  assert_seed_load_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(RES_OFS)) |=> result == $past(wdata));

  // R6
  assert_rsvd_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(IN_OFS) && size == 2'd3) |=> $stable(result));

  // R7
  assert_unmapped_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr != ADDR_W'(IN_OFS) && addr != ADDR_W'(RES_OFS)) |=> $stable(result));

  // R8
  assert_other_reads_zero_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(addr) != ADDR_W'(RES_OFS)) |-> rdata == 32'd0);

  // R9
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ready);

  // R10
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(result));
endmodule

bind mem_crc_checker mcc_checker #(
  .ADDR_W  (ADDR_W),
  .IN_OFS  (IN_OFS),
  .RES_OFS (RES_OFS),
  .RST_SEED(RST_SEED)
) u_mcc_checker (
  .clk   (clk),
  .rst   (rst),
  .addr  (addr),
  .wr_en (wr_en),
  .size  (size),
  .wdata (wdata),
  .rdata (rdata),
  .ready (ready),
  .result(result_q)
);

// File: tb/test_mem_crc_checker.sv
module test_mem_crc_checker;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_IN  = 4'h0;
  localparam logic [ADDR_W-1:0] A_RES = 4'h4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              wr_en = 1'b0;
  logic [1:0]        size = 2'd2;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              ready;

  int n_checks = 0;
  int n_fail   = 0;
  logic [31:0] model = 32'hFFFFFFFF;
  logic rd_issued = 1'b0;
  logic rd_flag   = 1'b0;
  logic done      = 1'b0;

  typedef struct { logic [31:0] exp; int req; } exp_t;
  exp_t sb [$];

  always #4 clk = ~clk;  // 125 MHz

  mem_crc_checker #(.ADDR_W(ADDR_W)) i_mem_crc_checker (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en),
    .size(size), .wdata(wdata), .rdata(rdata), .ready(ready)
  );

  function automatic logic [31:0] ref_fold(input logic [31:0] c,
                                           input logic [31:0] d, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      logic fb;
      fb = c[31] ^ d[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", req, act, exp);
    end
  endtask

  // Driver: one access per call, driven at the falling edge.
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    rd_issued = 1'b0;
    addr = a; wr_en = 1'b1; size = s; wdata = d;
    if (a == A_RES) model = d;
    else if (a == A_IN && s != 2'd3) model = ref_fold(model, d, 8 << s);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input int req);
    exp_t e;
    @(negedge clk);
    addr = a; wr_en = 1'b0; wdata = 32'hDEADBEEF;
    rd_issued = 1'b1;
    e.exp = (a == A_RES) ? model : 32'd0;
    e.req = req;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rd_issued = 1'b0; wr_en = 1'b0; addr = 4'h2;
    end
  endtask

  // Monitor: compare read data one cycle after each issued read.
  always @(posedge clk) rd_flag <= rd_issued;

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rd_flag) begin
        if (sb.size() == 0) check(8, 32'hX, 32'h0);
        else begin
          exp_t e;
          e = sb.pop_front();
          check(e.req, rdata, e.exp);
        end
      end
    end
  end

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(2);
    check(9, {31'd0, ready}, 32'd1);           // R9 ready after reset
    rd(A_RES, 1);                               // R1 reset value
    rd(A_IN, 8);                                // R8 input reads zero
    rd(4'h8, 8);                                // R8 unmapped reads zero

    // R4: known byte-string check value, upper bits garbage
    wr(A_RES, 2'd2, 32'hFFFFFFFF);
    for (int i = 0; i < 9; i++) wr(A_IN, 2'd0, {24'hA5C3F0, 8'h31 + 8'(i)});
    rd(A_RES, 4);
    idle(2);
    check(4, model, 32'h0376E6E7);              // R4 reference constant

    // R3: whole words
    wr(A_RES, 2'd2, 32'hFFFFFFFF);
    wr(A_IN, 2'd2, 32'h12345678);
    wr(A_IN, 2'd2, 32'h80000001);
    rd(A_RES, 3);
    wr(A_IN, 2'd2, 32'h00000000);
    rd(A_RES, 3);

    // R5: halfwords with garbage upper bits
    wr(A_RES, 2'd2, 32'h0);
    wr(A_IN, 2'd1, 32'hFFFF1234);
    wr(A_IN, 2'd1, 32'h0000ABCD);
    rd(A_RES, 5);

    // R2: seed written with a byte size code still loads all 32 bits
    wr(A_RES, 2'd0, 32'hC0FFEE11);
    rd(A_RES, 2);
    wr(A_IN, 2'd0, 32'h5A);
    rd(A_RES, 2);

    // R6: reserved size ignored
    wr(A_IN, 2'd3, 32'h13579BDF);
    rd(A_RES, 6);

    // R7: unmapped offsets ignored
    wr(4'h8, 2'd2, 32'h11111111);
    wr(4'hC, 2'd0, 32'h22);
    wr(4'h1, 2'd1, 32'h3333);
    rd(A_RES, 7);

    // R9: back-to-back mixed writes, ready held high
    wr(A_RES, 2'd2, 32'h6B8B4567);
    for (int i = 0; i < 24; i++) begin
      wr(A_IN, 2'(i % 3), $urandom);
      check(9, {31'd0, ready}, 32'd1);
    end
    rd(A_RES, 9);

    // R10: idle cycles hold the result
    idle(10);
    rd(A_RES, 10);

    // R8: read shows pre-edge value when a seed follows it
    rd(A_RES, 8);
    wr(A_RES, 2'd2, 32'h0BADF00D);
    rd(A_RES, 8);

    idle(4);
    if (sb.size() != 0) check(8, 32'(sb.size()), 32'd0);
    done = 1'b1;
    finish_run();
  end
endmodule